// File: doc/BRIEF.md
# Variable-Slot Reorder Retire Unit

This block is a circular reorder buffer that keeps instructions in program order from the moment they are allocated until they retire. When an instruction is allocated, it claims a number of consecutive slots equal to its micro-op count. The count is clamped so that an instruction always takes at least one slot and never more than the whole buffer. The caller receives a token, which is the index of the first slot the instruction claimed. The caller later presents that token on the execute port to mark the instruction as finished.

In every cycle the unit walks forward from the oldest entry. It retires finished entries one after another and stops at the first entry that has not finished. It also stops when it reaches a per-cycle limit. Each retired instruction appears on its own lane as a valid pulse together with its identifier. The slots held by retired instructions are returned to the free count at the clock edge that closes the cycle. The free-slot count and an empty flag are visible at all times.

Top module: `slot_rob`

## Requirements
- R1: The reserved slot count is the micro-op count clamped: a count of 0 reserves 1 slot, and a count above DEPTH reserves DEPTH slots.
- R2: `rsvToken` always shows the allocation index, which is 0 after reset. An accepted reservation is given that index as its token, and the index then advances by the reserved count modulo DEPTH.
- R3: `availSlots` is DEPTH after reset. It drops by the reserved count at the clock edge that accepts a reservation.
- R4: A newly reserved entry is pending. It does not retire until its token has been marked executed.
- R5: A pulse on `exeValid` with `exeToken` marks that entry executed. Marking a token that holds no live entry, or one that is already executed, is a caller error.
- R6: Retirement is in program order and stops at the first unexecuted entry. An executed younger entry waits for every older entry. A retired entry moves the head by its own slot count and returns that many slots at the closing clock edge.
- R7: `rsvReady` is 1 only when `availSlots` is at least the reserved count. A request made while `rsvReady` is 0 changes neither the token nor the free count.
- R8: At most MAX_RETIRE entries retire per cycle. In a retire cycle, `retValid` bits are set contiguously from lane 0, lane 0 holds the oldest entry, and the identifier of lane k is `retId[k*ID_W +: ID_W]`. Entries beyond the limit retire in a later cycle.
- R9: `empty` is 1 exactly when `availSlots` equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rsvValid | input | 1 | Reservation request |
| rsvId | input | ID_W | Identifier of the instruction being reserved |
| rsvUops | input | UOP_W | Micro-op count of the instruction |
| rsvReady | output | 1 | Enough free slots for the clamped count |
| rsvToken | output | PTR_W | Current allocation index; the token of an accepted reservation |
| exeValid | input | 1 | Execute-done strobe |
| exeToken | input | PTR_W | Token of the instruction that finished |
| retValid | output | MAX_RETIRE | Per-lane retire pulse |
| retId | output | MAX_RETIRE*ID_W | Per-lane retired identifier |
| availSlots | output | CNT_W | Number of free slots |
| empty | output | 1 | No slot is in use |

## Verification
The bench builds the unit with DEPTH 6, MAX_RETIRE 2 and a 4-bit micro-op count. A depth that is not a power of two forces the pointers through a wrap that cannot be done by bit truncation. A 4-bit count can exceed the depth, which exercises the upper clamp in R1, including a single instruction that fills the whole buffer. A limit of two lanes, below the three finished entries the bench lines up, shows the overflow entries retiring in the following cycle. The bench also checks refusal when the buffer is full and the stall of an executed younger entry behind an older one.

// File: rtl/slot_rob_pkg.sv
package slot_rob_pkg;

  typedef struct packed {
    logic rsvWe;
    logic exeWe;
  } robStrobe_t;

  function automatic int wrapAdd(int a, int b, int depth);
    int s;
    s = a + b;
    return (s >= depth) ? s - depth : s;
  endfunction

endpackage

// File: rtl/slot_rob_ctrl.sv
module slot_rob_ctrl
  import slot_rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int UOP_W = 4,
  parameter int RET_W = DEPTH,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              rsvValid,
  input  logic [UOP_W-1:0]                  rsvUops,
  input  logic                              exeValid,
  input  logic [DEPTH-1:0]                  validVec,
  input  logic [DEPTH-1:0]                  doneVec,
  input  logic [DEPTH-1:0][CNT_W-1:0]       cntArr,
  output robStrobe_t                        strobe,
  output logic [PTR_W-1:0]                  allocPtr,
  output logic [CNT_W-1:0]                  normCnt,
  output logic                              rsvReady,
  output logic [RET_W-1:0]                  retValid,
  output logic [RET_W-1:0][PTR_W-1:0]       retIdx,
  output logic [DEPTH-1:0]                  popMask,
  output logic [CNT_W-1:0]                  availSlots
);

  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] nextHead;
  logic [PTR_W-1:0] scanIdx;
  logic [CNT_W:0]   scanCum;
  logic [CNT_W:0]   usedSlots;
  logic             scanStop;
  logic [CNT_W-1:0] retCnt;
  logic             accept;

  always_comb begin
    if (rsvUops == '0) normCnt = CNT_W'(1);
    else if (int'(rsvUops) > DEPTH) normCnt = CNT_W'(DEPTH);
    else normCnt = CNT_W'(rsvUops);
  end

  assign rsvReady = (availSlots >= normCnt);
  assign accept   = rsvValid && rsvReady;
  assign strobe.rsvWe = accept;
  assign strobe.exeWe = exeValid;
  assign usedSlots = (CNT_W + 1)'(DEPTH) - {1'b0, availSlots};

  always_comb begin
    popMask  = '0;
    retValid = '0;
    retIdx   = '0;
    scanIdx  = headPtr;
    scanCum  = '0;
    scanStop = 1'b0;
    for (int k = 0; k < RET_W; k++) begin
      retIdx[k] = scanIdx;
      if (!scanStop && (scanCum < usedSlots) && validVec[scanIdx] && doneVec[scanIdx]) begin
        retValid[k]      = 1'b1;
        popMask[scanIdx] = 1'b1;
        scanCum          = scanCum + (CNT_W + 1)'(cntArr[scanIdx]);
        scanIdx          = PTR_W'(wrapAdd(int'(scanIdx), int'(cntArr[scanIdx]), DEPTH));
      end else begin
        scanStop = 1'b1;
      end
    end
    nextHead = scanIdx;
    retCnt   = CNT_W'(scanCum);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr    <= '0;
      allocPtr   <= '0;
      availSlots <= CNT_W'(DEPTH);
    end else begin
      headPtr <= nextHead;
      if (accept) allocPtr <= PTR_W'(wrapAdd(int'(allocPtr), int'(normCnt), DEPTH));
      availSlots <= availSlots - (accept ? normCnt : '0) + retCnt;
    end
  end

  p_avail_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    availSlots <= CNT_W'(DEPTH));

  p_refuse_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rsvValid && !rsvReady) |=> (allocPtr == $past(allocPtr)));

  for (genvar g = 1; g < RET_W; g++) begin : gLaneOrder
    p_lane_order_r8: assert property (@(posedge clk) disable iff (!rstN)
      retValid[g] |-> retValid[g-1]);
  end

endmodule

// File: rtl/slot_rob_data.sv
module slot_rob_data
  import slot_rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int ID_W  = 8,
  parameter int RET_W = DEPTH,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  robStrobe_t                    strobe,
  input  logic [PTR_W-1:0]              rsvIdx,
  input  logic [CNT_W-1:0]              rsvCnt,
  input  logic [ID_W-1:0]               rsvId,
  input  logic [PTR_W-1:0]              exeIdx,
  input  logic [DEPTH-1:0]              popMask,
  input  logic [RET_W-1:0][PTR_W-1:0]   retIdx,
  output logic [DEPTH-1:0]              validVec,
  output logic [DEPTH-1:0]              doneVec,
  output logic [DEPTH-1:0][CNT_W-1:0]   cntArr,
  output logic [RET_W-1:0][ID_W-1:0]    retIdArr
);

  logic [DEPTH-1:0][ID_W-1:0] idArr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
      doneVec  <= '0;
      cntArr   <= '0;
      idArr    <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (popMask[i]) begin
          validVec[i] <= 1'b0;
          doneVec[i]  <= 1'b0;
        end
      end
      if (strobe.exeWe) doneVec[exeIdx] <= 1'b1;
      if (strobe.rsvWe) begin
        validVec[rsvIdx] <= 1'b1;
        doneVec[rsvIdx]  <= 1'b0;
        cntArr[rsvIdx]   <= rsvCnt;
        idArr[rsvIdx]    <= rsvId;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < RET_W; k++) retIdArr[k] = idArr[retIdx[k]];
  end

  p_entry_pending_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rsvWe |=> (validVec[$past(rsvIdx)] && !doneVec[$past(rsvIdx)]));

  p_exe_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.exeWe |-> (validVec[exeIdx] && !doneVec[exeIdx]));

endmodule

// File: rtl/slot_rob.sv
module slot_rob
  import slot_rob_pkg::*;
#(
  parameter int DEPTH      = 8,
  parameter int ID_W       = 8,
  parameter int UOP_W      = 4,
  parameter int MAX_RETIRE = DEPTH,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         rsvValid,
  input  logic [ID_W-1:0]              rsvId,
  input  logic [UOP_W-1:0]             rsvUops,
  output logic                         rsvReady,
  output logic [PTR_W-1:0]             rsvToken,
  input  logic                         exeValid,
  input  logic [PTR_W-1:0]             exeToken,
  output logic [MAX_RETIRE-1:0]        retValid,
  output logic [MAX_RETIRE*ID_W-1:0]   retId,
  output logic [CNT_W-1:0]             availSlots,
  output logic                         empty
);

  robStrobe_t                         strobe;
  logic [CNT_W-1:0]                   normCnt;
  logic [DEPTH-1:0]                   validVec;
  logic [DEPTH-1:0]                   doneVec;
  logic [DEPTH-1:0][CNT_W-1:0]        cntArr;
  logic [DEPTH-1:0]                   popMask;
  logic [MAX_RETIRE-1:0][PTR_W-1:0]   retIdx;
  logic [MAX_RETIRE-1:0][ID_W-1:0]    retIdArr;

  slot_rob_ctrl #(.DEPTH(DEPTH), .UOP_W(UOP_W), .RET_W(MAX_RETIRE)) uCtrl (
    .clk(clk), .rstN(rstN), .rsvValid(rsvValid), .rsvUops(rsvUops),
    .exeValid(exeValid), .validVec(validVec), .doneVec(doneVec), .cntArr(cntArr),
    .strobe(strobe), .allocPtr(rsvToken), .normCnt(normCnt), .rsvReady(rsvReady),
    .retValid(retValid), .retIdx(retIdx), .popMask(popMask), .availSlots(availSlots)
  );

  slot_rob_data #(.DEPTH(DEPTH), .ID_W(ID_W), .RET_W(MAX_RETIRE)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rsvIdx(rsvToken), .rsvCnt(normCnt),
    .rsvId(rsvId), .exeIdx(exeToken), .popMask(popMask), .retIdx(retIdx),
    .validVec(validVec), .doneVec(doneVec), .cntArr(cntArr), .retIdArr(retIdArr)
  );

  assign retId = retIdArr;
  assign empty = (availSlots == CNT_W'(DEPTH));

  p_empty_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> (retValid == '0));

endmodule

// File: tb/tb_slot_rob.sv
`timescale 1ns/1ps
module tb_slot_rob;
  localparam int DEPTH = 6;
  localparam int ID_W  = 8;
  localparam int UOP_W = 4;
  localparam int RETW  = 2;
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rsvValid = 1'b0;
  logic [ID_W-1:0] rsvId = '0;
  logic [UOP_W-1:0] rsvUops = '0;
  logic rsvReady;
  logic [PTR_W-1:0] rsvToken;
  logic exeValid = 1'b0;
  logic [PTR_W-1:0] exeToken = '0;
  logic [RETW-1:0] retValid;
  logic [RETW*ID_W-1:0] retId;
  logic [CNT_W-1:0] availSlots;
  logic empty;

  int checks = 0;
  int errors = 0;
  int expAlloc = 0;
  int expAvail = DEPTH;
  bit finished = 0;

  always #2.5 clk = ~clk;

  slot_rob #(.DEPTH(DEPTH), .ID_W(ID_W), .UOP_W(UOP_W), .MAX_RETIRE(RETW)) dut (
    .clk(clk), .rstN(rstN), .rsvValid(rsvValid), .rsvId(rsvId), .rsvUops(rsvUops),
    .rsvReady(rsvReady), .rsvToken(rsvToken), .exeValid(exeValid), .exeToken(exeToken),
    .retValid(retValid), .retId(retId), .availSlots(availSlots), .empty(empty)
  );

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int normOf(int u);
    if (u == 0) return 1;
    if (u > DEPTH) return DEPTH;
    return u;
  endfunction

  task automatic checkState(string req);
    check(req, "availSlots", int'(availSlots), expAvail);
    check(req, "rsvToken", int'(rsvToken), expAlloc);
    check(req, "empty", int'(empty), (expAvail == DEPTH) ? 1 : 0);
  endtask

  task automatic reserve(int id, int uops, int expReady);
    int n;
    n = normOf(uops);
    @(negedge clk);
    rsvValid = 1'b1; rsvId = ID_W'(id); rsvUops = UOP_W'(uops);
    #1;
    check("R7", "rsvReady", int'(rsvReady), expReady);
    check("R2", "token offered", int'(rsvToken), expAlloc);
    @(posedge clk);
    @(negedge clk);
    rsvValid = 1'b0;
    #1;
    if (expReady == 1) begin
      expAlloc = (expAlloc + n) % DEPTH;
      expAvail = expAvail - n;
    end
    checkState("R3");
  endtask

  task automatic execute(int tok);
    @(negedge clk);
    exeValid = 1'b1; exeToken = PTR_W'(tok);
    @(posedge clk);
    @(negedge clk);
    exeValid = 1'b0;
    #1;
  endtask

  task automatic stepCycle();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic testReset();
    checkState("R9");
    check("R8", "retValid at reset", int'(retValid), 0);
  endtask

  task automatic testClampAndPending();
    reserve(8'h11, 0, 1);
    check("R1", "zero uops takes one slot", int'(availSlots), DEPTH - 1);
    reserve(8'h22, 3, 1);
    check("R2", "token advanced by 3", int'(rsvToken), 4);
    check("R4", "pending entries do not retire", int'(retValid), 0);
  endtask

  task automatic testRefuse();
    reserve(8'h33, 3, 0);
    check("R7", "refused request keeps free count", int'(availSlots), 2);
  endtask

  task automatic testInOrder();
    execute(1);
    check("R6", "younger waits for older", int'(retValid), 0);
    stepCycle();
    check("R6", "younger still waits", int'(retValid), 0);
    execute(0);
    check("R6", "both lanes retire", int'(retValid), 3);
    check("R8", "lane0 oldest id", int'(retId[ID_W-1:0]), 8'h11);
    check("R8", "lane1 id", int'(retId[2*ID_W-1:ID_W]), 8'h22);
    stepCycle();
    expAvail = DEPTH;
    check("R6", "slots returned", int'(availSlots), DEPTH);
    check("R9", "empty after drain", int'(empty), 1);
    check("R6", "no further retire", int'(retValid), 0);
  endtask

  task automatic testFullClamp();
    reserve(8'h44, 15, 1);
    check("R1", "large count clamped to depth", int'(availSlots), 0);
    check("R2", "token wraps modulo depth", int'(rsvToken), 4);
    reserve(8'h55, 0, 0);
    execute(4);
    check("R5", "executed entry retires", int'(retValid), 1);
    check("R5", "retired id", int'(retId[ID_W-1:0]), 8'h44);
    stepCycle();
    expAvail = DEPTH;
    check("R6", "full buffer freed", int'(availSlots), DEPTH);
  endtask

  task automatic testRetireLimit();
    reserve(8'hA1, 1, 1);
    reserve(8'hB2, 1, 1);
    reserve(8'hC3, 1, 1);
    check("R2", "token wrapped past end", int'(rsvToken), 1);
    execute(0);
    check("R6", "wait for head", int'(retValid), 0);
    execute(5);
    check("R6", "wait for head again", int'(retValid), 0);
    execute(4);
    check("R8", "limited to two lanes", int'(retValid), 3);
    check("R8", "lane0 id", int'(retId[ID_W-1:0]), 8'hA1);
    check("R8", "lane1 id", int'(retId[2*ID_W-1:ID_W]), 8'hB2);
    stepCycle();
    check("R8", "remaining entry next cycle", int'(retValid), 1);
    check("R8", "remaining id", int'(retId[ID_W-1:0]), 8'hC3);
    check("R6", "two slots returned", int'(availSlots), 5);
    stepCycle();
    expAvail = DEPTH;
    checkState("R9");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    testReset();
    testClampAndPending();
    testRefuse();
    testInOrder();
    testFullClamp();
    testRetireLimit();
    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule